// File: doc/BRIEF.md
# HI/LO Multiply-Divide Unit

This unit holds the HI/LO register pair of a 32-bit integer core, together with the multiply and divide operations that fill it. An operation is issued with a one-cycle `start` pulse. The pulse carries a 6-bit function code, two 32-bit operands and a destination register index. Moves to and from HI and LO and both multiplies finish in the cycle after issue. The divides run through a restoring divider, one quotient bit per cycle.

A 64-bit product is split across the pair: the upper half goes to HI and the lower half to LO. A divide leaves the quotient in LO and the remainder in HI. Reads of HI or LO come back on a writeback port with the destination index. The writeback is suppressed when the destination is register 0. A `done` pulse marks the completion of every recognised operation. While a divide is in flight, `busy` is high and new issues are dropped. Stalling the rest of the pipeline is the job of the surrounding logic.

Top module: `muldiv_hilo`

## Requirements
- R1: After reset, HI and LO are zero and busy, done and wb_en are low.
- R2: Function 0x10 returns HI and function 0x12 returns LO. In the cycle after issue, done and wb_en are high, wb_data holds the value and wb_reg holds the destination index.
- R3: Function 0x11 copies rs into HI and function 0x13 copies rs into LO. Neither produces a writeback, and both pulse done in the next cycle.
- R4: Function 0x18 forms the signed 64-bit product of rs and rt. The upper 32 bits go to HI and the lower 32 bits to LO. The result is visible, with done high and busy low, in the cycle after issue.
- R5: Function 0x19 forms the same product with both operands taken as unsigned.
- R6: Function 0x1a is a signed divide of rs by rt. The quotient is truncated toward zero and goes to LO. The remainder takes the sign of the dividend and goes to HI. 0x80000000 divided by -1 gives LO = 0x80000000 and HI = 0.
- R7: Function 0x1b is the unsigned divide, with the same placement of quotient and remainder.
- R8: A divide holds busy high for exactly the 32 cycles after issue. Done is high in the first cycle in which busy is low again. No other function raises busy.
- R9: A divide by zero of either kind completes in the same 32 cycles. It leaves LO = 0xFFFFFFFF and HI = the dividend.
- R10: An HI or LO read with destination 0 keeps wb_en low but still pulses done.
- R11: A start while busy is high is ignored. A start with any function code other than 0x10 to 0x13 and 0x18 to 0x1b is also ignored. In both cases done stays low for it and HI and LO are unchanged.
- R12: An operation issued in the cycle in which done is high is accepted. If it reads HI or LO, it returns the values just written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Issue pulse for the operation on func |
| func | input | 6 | Function code |
| rs_val | input | 32 | First operand; dividend; value moved into HI or LO |
| rt_val | input | 32 | Second operand; divisor |
| dst | input | 5 | Destination register index for HI or LO reads |
| busy | output | 1 | Divide in progress; issues are dropped |
| done | output | 1 | One-cycle completion pulse |
| wb_en | output | 1 | Register writeback valid |
| wb_reg | output | 5 | Writeback register index |
| wb_data | output | 32 | Writeback value |

## Verification
Two events can coincide in one cycle: a divide writing its final quotient and remainder, and a fresh issue that reads the pair or overwrites it. The bench issues its next operation on the exact cycle that done is high after every divide. That next operation is often an HI or LO read, and its writeback value is compared with the divide result computed by the bench model. The bench also pulses start with a move-to-HI in the middle of a divide. It then checks that no done pulse appears for that issue and that the later read returns the divide result, not the moved value.

// File: rtl/muldiv_hilo.sv
module muldiv_hilo #(
  parameter int W = 32,
  parameter int RW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [5:0]    func,
  input  logic [W-1:0]  rs_val,
  input  logic [W-1:0]  rt_val,
  input  logic [RW-1:0] dst,
  output logic          busy,
  output logic          done,
  output logic          wb_en,
  output logic [RW-1:0] wb_reg,
  output logic [W-1:0]  wb_data
);
  localparam int CW = $clog2(W + 1);
  localparam logic [5:0] F_RDHI = 6'h10, F_WRHI = 6'h11, F_RDLO = 6'h12, F_WRLO = 6'h13;
  localparam logic [5:0] F_MUL = 6'h18, F_MULU = 6'h19, F_DIV = 6'h1a, F_DIVU = 6'h1b;

  logic [W-1:0]  hi_q, lo_q, rem_q, quo_q, dvs_q, dvd_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q, done_q, wb_en_q, negq_q, negr_q, dz_q;
  logic [RW-1:0] wb_reg_q;
  logic [W-1:0]  wb_data_q;

  wire issue  = start && !busy_q;
  wire sgn    = (func == F_DIV) || (func == F_MUL);
  wire a_neg  = sgn && rs_val[W-1];
  wire b_neg  = sgn && rt_val[W-1];
  wire [W-1:0] a_mag = a_neg ? -rs_val : rs_val;
  wire [W-1:0] b_mag = b_neg ? -rt_val : rt_val;

  wire [2*W-1:0] ext_a = {{W{a_neg}}, rs_val};
  wire [2*W-1:0] ext_b = {{W{b_neg}}, rt_val};
  wire [2*W-1:0] prod  = ext_a * ext_b;

  wire [W:0]   sh    = {rem_q, quo_q[W-1]};
  wire [W:0]   diff  = sh - {1'b0, dvs_q};
  wire         fit   = !diff[W];
  wire [W-1:0] rem_n = fit ? diff[W-1:0] : sh[W-1:0];
  wire [W-1:0] quo_n = {quo_q[W-2:0], fit};
  wire [W-1:0] q_fin = dz_q ? '1 : (negq_q ? -quo_n : quo_n);
  wire [W-1:0] r_fin = dz_q ? dvd_q : (negr_q ? -rem_n : rem_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0; lo_q <= '0; rem_q <= '0; quo_q <= '0; dvs_q <= '0; dvd_q <= '0;
      cnt_q <= '0; busy_q <= 1'b0; done_q <= 1'b0; wb_en_q <= 1'b0;
      negq_q <= 1'b0; negr_q <= 1'b0; dz_q <= 1'b0;
      wb_reg_q <= '0; wb_data_q <= '0;
    end else begin
      done_q  <= 1'b0;
      wb_en_q <= 1'b0;
      if (busy_q) begin
        rem_q <= rem_n;
        quo_q <= quo_n;
        cnt_q <= cnt_q - CW'(1);
        if (cnt_q == CW'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          hi_q   <= r_fin;
          lo_q   <= q_fin;
        end
      end else if (issue) begin
        case (func)
          F_RDHI, F_RDLO: begin
            done_q    <= 1'b1;
            wb_en_q   <= (dst != '0);
            wb_reg_q  <= dst;
            wb_data_q <= (func == F_RDHI) ? hi_q : lo_q;
          end
          F_WRHI: begin hi_q <= rs_val; done_q <= 1'b1; end
          F_WRLO: begin lo_q <= rs_val; done_q <= 1'b1; end
          F_MUL, F_MULU: begin
            {hi_q, lo_q} <= prod;
            done_q <= 1'b1;
          end
          F_DIV, F_DIVU: begin
            busy_q <= 1'b1;
            cnt_q  <= CW'(W);
            rem_q  <= '0;
            quo_q  <= a_mag;
            dvs_q  <= b_mag;
            dvd_q  <= rs_val;
            negq_q <= a_neg ^ b_neg;
            negr_q <= a_neg;
            dz_q   <= (rt_val == '0);
          end
          default: ;
        endcase
      end
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign wb_en   = wb_en_q;
  assign wb_reg  = wb_reg_q;
  assign wb_data = wb_data_q;
endmodule

// File: rtl/muldiv_hilo_chk.sv
module muldiv_hilo_chk #(
  parameter int W = 32,
  parameter int RW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [5:0]    func,
  input logic          busy,
  input logic          done,
  input logic          wb_en,
  input logic [RW-1:0] wb_reg,
  input logic [W-1:0]  hi_q,
  input logic [W-1:0]  lo_q
);
  logic [7:0] busy_cyc;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) busy_cyc <= '0;
    else if (!busy) busy_cyc <= '0;
    else busy_cyc <= busy_cyc + 8'd1;

  // R8
  div_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && (func == 6'h1a || func == 6'h1b) |=> busy);
  // R8
  div_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_cyc == 8'(W)) && done);
  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R2
  wb_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> done);
  // R10
  wb_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> wb_reg != '0);
  // R4
  mul_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && (func == 6'h18 || func == 6'h19) |=> done && !busy);
  // R11
  hold_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(hi_q) && $stable(lo_q));
endmodule

bind muldiv_hilo muldiv_hilo_chk #(.W(W), .RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .func(func), .busy(busy),
  .done(done), .wb_en(wb_en), .wb_reg(wb_reg), .hi_q(hi_q), .lo_q(lo_q)
);

// File: tb/sim_muldiv_hilo.sv
module sim_muldiv_hilo;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, start;
  logic [5:0] func;
  logic [31:0] rs_val, rt_val;
  logic [4:0] dst;
  wire busy, done, wb_en;
  wire [4:0] wb_reg;
  wire [31:0] wb_data;

  int n_chk = 0, n_fail = 0;
  logic [31:0] ehi = '0, elo = '0;

  muldiv_hilo u0 (.clk(clk), .rst_n(rst_n), .start(start), .func(func), .rs_val(rs_val),
    .rt_val(rt_val), .dst(dst), .busy(busy), .done(done), .wb_en(wb_en),
    .wb_reg(wb_reg), .wb_data(wb_data));

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit valid_f(input logic [5:0] f);
    return (f >= 6'h10 && f <= 6'h13) || (f >= 6'h18 && f <= 6'h1b);
  endfunction

  task automatic model(input logic [5:0] f, input logic [31:0] a, input logic [31:0] b);
    longint sa, sb, p;
    logic [63:0] pu;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    case (f)
      6'h11: ehi = a;
      6'h13: elo = a;
      6'h18: begin p = sa * sb; {ehi, elo} = p; end
      6'h19: begin pu = {32'd0, a} * {32'd0, b}; {ehi, elo} = pu; end
      6'h1a: if (b == 0) begin elo = '1; ehi = a; end
             else begin elo = 32'(sa / sb); ehi = 32'(sa % sb); end
      6'h1b: if (b == 0) begin elo = '1; ehi = a; end
             else begin elo = a / b; ehi = a % b; end
      default: ;
    endcase
  endtask

  // Called and returns at a falling edge; the return edge lies in the done cycle.
  task automatic do_op(input logic [5:0] f, input logic [31:0] a, input logic [31:0] b,
                       input logic [4:0] d, input string tag);
    bit v, is_div, rd;
    logic [31:0] exp_wb;
    int cnt;
    v = valid_f(f);
    is_div = (f == 6'h1a) || (f == 6'h1b);
    rd = (f == 6'h10) || (f == 6'h12);
    exp_wb = (f == 6'h10) ? ehi : elo;
    func = f; rs_val = a; rt_val = b; dst = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (is_div) begin
      cnt = 0;
      while (busy && cnt < 100) begin cnt++; @(negedge clk); end
      chk(cnt == 32, {tag, " R8 busy length"}, 64'(cnt), 64'd32);
    end else begin
      chk(busy == 1'b0, {tag, " R8 no busy"}, 64'(busy), 64'd0);
    end
    model(f, a, b);
    chk(done == v, {tag, " done (R11 if invalid)"}, 64'(done), 64'(v));
    chk(wb_en == (rd && d != 0), {tag, " wb_en R10"}, 64'(wb_en), 64'(rd && d != 0));
    if (rd && d != 0) begin
      chk(wb_data == exp_wb, {tag, " wb_data R2"}, 64'(wb_data), 64'(exp_wb));
      chk(wb_reg == d, {tag, " wb_reg R2"}, 64'(wb_reg), 64'(d));
    end
  endtask

  task automatic rd_pair(input string tag);
    do_op(6'h10, 32'h0, 32'h0, 5'd9, {tag, " readHI"});
    do_op(6'h12, 32'h0, 32'h0, 5'd31, {tag, " readLO"});
  endtask

  function automatic logic [31:0] pick();
    case ($urandom % 6)
      0: return 32'h0;
      1: return 32'hFFFF_FFFF;
      2: return 32'h8000_0000;
      3: return 32'($urandom % 16);
      default: return $urandom;
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [5:0] fl [10];
    void'($urandom(32'd4321));
    fl = '{6'h10, 6'h11, 6'h12, 6'h13, 6'h18, 6'h19, 6'h1a, 6'h1b, 6'h10, 6'h12};
    rst_n = 1'b0; start = 1'b0; func = '0; rs_val = '0; rt_val = '0; dst = '0;
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && wb_en == 0, "R1 outputs idle", {busy, done, wb_en}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    rd_pair("R1 reset pair");

    do_op(6'h11, 32'hDEAD_BEEF, 32'h0, 5'd0, "R3 move HI");
    do_op(6'h13, 32'h1234_5678, 32'h0, 5'd4, "R3 move LO");
    rd_pair("R3 readback");
    do_op(6'h10, 32'h0, 32'h0, 5'd0, "R10 read to r0");

    do_op(6'h18, 32'hFFFF_FFFD, 32'd7, 5'd0, "R4 -3*7");
    rd_pair("R4");
    do_op(6'h18, 32'h8000_0000, 32'h8000_0000, 5'd0, "R4 min*min");
    rd_pair("R4");
    do_op(6'h19, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd0, "R5 max*max");
    rd_pair("R5");

    do_op(6'h1a, 32'hFFFF_FFF9, 32'd2, 5'd0, "R6 -7/2");
    rd_pair("R6 R12");
    do_op(6'h1a, 32'd7, 32'hFFFF_FFFE, 5'd0, "R6 7/-2");
    rd_pair("R6 R12");
    do_op(6'h1a, 32'h8000_0000, 32'hFFFF_FFFF, 5'd0, "R6 min/-1");
    rd_pair("R6 R12");
    do_op(6'h1b, 32'hFFFF_FFFF, 32'd7, 5'd0, "R7 divu");
    rd_pair("R7 R12");
    do_op(6'h1a, 32'hFFFF_FF00, 32'd0, 5'd0, "R9 signed /0");
    rd_pair("R9");
    do_op(6'h1b, 32'h0000_0123, 32'd0, 5'd0, "R9 unsigned /0");
    rd_pair("R9");

    do_op(6'h05, 32'h5555_5555, 32'h1, 5'd3, "R11 unknown code");
    do_op(6'h14, 32'h5555_5555, 32'h1, 5'd3, "R11 unknown code");
    rd_pair("R11 pair kept");

    // R11: a move issued during a divide is dropped
    func = 6'h1b; rs_val = 32'd1000; rt_val = 32'd33; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    func = 6'h11; rs_val = 32'hBAD0_BAD0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done == 0, "R11 no done for dropped start", 64'(done), 0);
    begin
      int cnt = 0;
      while (busy && cnt < 100) begin cnt++; @(negedge clk); end
    end
    chk(done == 1, "R8 divide done", 64'(done), 1);
    model(6'h1b, 32'd1000, 32'd33);
    do_op(6'h10, 32'h0, 32'h0, 5'd2, "R11 R12 HI after drop");
    do_op(6'h12, 32'h0, 32'h0, 5'd2, "R11 LO after drop");

    for (int i = 0; i < 200; i++) begin
      logic [5:0] f;
      f = ($urandom % 16 == 0) ? 6'h1f : fl[$urandom % 10];
      do_op(f, pick(), pick(), 5'($urandom), "random R2 R4 R5 R6 R7");
    end
    rd_pair("random final");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule